// File: doc/BRIEF.md
# Word-Serial Table CRC Engine

This block computes a CRC over a stream of 32-bit words. Software first writes a reflected generator polynomial. The engine then fills an internal 256-entry lookup table, one entry per cycle, and reports that the table is ready. Next, software loads a word count and a seed, and sets the run bit with the calculate mode selected. The engine takes words from a valid/ready input. It folds the four bytes of each word into the running CRC, least significant byte first, one table lookup per cycle. It decrements the count once per word.

When the count reaches zero, the engine captures the final CRC in a result register and sets a count-expired status flag. If that source is enabled, it raises an interrupt. The count is then reloaded from a reload register. A reload value of zero stops the run. A nonzero reload value starts a further run that continues from the running CRC. Software clears the run bit when it is done.

Input back-pressure works as follows. `s_ready` is low until the table is ready, whenever the run bit is clear or the mode is not calculate, whenever the count is zero, and for the four cycles in which an accepted word is being folded. A word is taken on a clock edge at which both `s_valid` and `s_ready` are high. The source must hold `s_data` stable while `s_valid` is high.

Top module: `crc_word_engine`

## Requirements
- R1: After reset, every register reads zero, `s_ready` is low and `irq` is low.
- R2: A write to the polynomial register (address 3) clears status bit 0 (table ready). Status bit 0 sets on the 256th rising edge after the edge that took the write, and `s_ready` stays low while it is clear.
- R3: Each word updates the CRC byte by byte, least significant byte first, as crc = (crc >> 8) ^ T[(crc ^ byte) & 0xFF]. Table entry T[i] is i shifted right 8 times, and the polynomial is XORed in after each shift whose dropped bit was 1. The CRC starts from the seed written to address 4, and no final inversion is applied.
- R4: `s_ready` is high only when all of these hold: control bit 0 (run) is 1, control bits [2:1] (mode) are 01, the table is ready, the count is nonzero, and no word is in progress. After a word is accepted, `s_ready` is low on the next cycle.
- R5: Each word decrements the count (address 6). When the count reaches zero, the result register (address 5) captures the final CRC and status bit 1 (count expired) sets. The count then reloads from address 7; with a reload of zero, `s_ready` stays low.
- R6: With a nonzero reload, the engine accepts a further run of words, and the CRC continues from the value it had at expiry.
- R7: Writing 1 to status bit 1 clears it. Writing 0 has no effect, and writes never clear status bit 0.
- R8: The interrupt-enable register (address 2, bits [1:0]) is write-1-to-set: a written 0 leaves a bit unchanged. `irq` is high when any status bit and its matching enable bit are both 1.
- R9: While run is 1, writes to the polynomial, seed and count registers are ignored.
- R10: A mode other than 01 keeps `s_ready` low even with run set.
- R11: Address 4 reads back the running CRC: it returns the seed before a run and the CRC as it stands after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Engine accepts a word |
| s_data | input | 32 | Input word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with its default parameters: 32-bit words, 8-bit table index and 16-bit count. These values give the full 256-cycle table fill, so the exact cycle at which the table becomes ready can be checked. They also give a four-lookup fold per word, which a bitwise reference CRC in the bench can check. Runs of one to five words cover the count reaching zero after a single decrement and after several. A nonzero reload covers the continued CRC across two runs.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_IEN  = 3'd2,
    RA_POLY = 3'd3,
    RA_CUR  = 3'd4,
    RA_RES  = 3'd5,
    RA_CNT  = 3'd6,
    RA_RLD  = 3'd7
  } reg_addr_e;

  localparam logic [1:0] MODE_CALC = 2'b01;
  localparam int ST_TBL = 0;
  localparam int ST_EXP = 1;
endpackage

// File: rtl/crc_lut.sv
module crc_lut #(
  parameter int W     = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     poly,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic             done
);
  localparam int DEPTH = 1 << IDX_W;

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     poly_q;
  logic [IDX_W-1:0] gen_idx;
  logic             gen_act;
  logic [W-1:0]     gen_val;

  // One table entry: the index pushed through IDX_W reflected shift steps.
  function automatic logic [W-1:0] entry(input logic [IDX_W-1:0] i,
                                         input logic [W-1:0] p);
    logic [W-1:0] c;
    c = W'(i);
    for (int b = 0; b < IDX_W; b++)
      c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    return c;
  endfunction

  always_comb gen_val = entry(gen_idx, poly_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q  <= '0;
      gen_idx <= '0;
      gen_act <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      poly_q  <= poly;
      gen_idx <= '0;
      gen_act <= 1'b1;
      done    <= 1'b0;
    end else if (gen_act) begin
      gen_idx <= gen_idx + 1'b1;
      if (gen_idx == IDX_W'(DEPTH - 1)) begin
        gen_act <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (gen_act) mem[gen_idx] <= gen_val;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/crc_word_dp.sv
module crc_word_dp #(
  parameter int W     = 32,
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             seed_we,
  input  logic [W-1:0]     seed,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [CNT_W-1:0] reload,
  input  logic             s_valid,
  input  logic [W-1:0]     s_data,
  output logic             s_ready,
  output logic [IDX_W-1:0] lut_idx,
  input  logic [W-1:0]     lut_data,
  output logic [W-1:0]     crc_cur,
  output logic [CNT_W-1:0] cnt_cur,
  output logic             busy,
  output logic             done
);
  localparam int NB    = W / IDX_W;
  localparam int SEL_W = $clog2(NB);

  logic [SEL_W-1:0] sel_q;
  logic [W-1:0]     word_q;
  logic [IDX_W-1:0] byte_cur;
  logic             last;

  assign byte_cur = word_q[sel_q*IDX_W +: IDX_W];
  assign lut_idx  = crc_cur[IDX_W-1:0] ^ byte_cur;
  assign last     = busy && (sel_q == SEL_W'(NB - 1));
  assign s_ready  = go && !busy && (cnt_cur != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sel_q   <= '0;
      word_q  <= '0;
      crc_cur <= '0;
      cnt_cur <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (seed_we) crc_cur <= seed;
      if (cnt_we)  cnt_cur <= cnt_in;
      if (s_valid && s_ready) begin
        busy   <= 1'b1;
        word_q <= s_data;
        sel_q  <= '0;
      end else if (busy) begin
        crc_cur <= (crc_cur >> IDX_W) ^ lut_data;
        sel_q   <= sel_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          if (cnt_cur == CNT_W'(1)) begin
            cnt_cur <= reload;
            done    <= 1'b1;
          end else begin
            cnt_cur <= cnt_cur - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine #(
  parameter int W      = 32,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [W-1:0]      s_data,
  output logic              irq
);
  import crc_eng_pkg::*;

  logic [2:0]       ctrl_q;
  logic             stat_exp;
  logic [1:0]       ien_q;
  logic [W-1:0]     result_q;
  logic [CNT_W-1:0] reload_q;

  logic             run, lut_done, locked, go;
  logic             poly_we, seed_we, cnt_we;
  logic [IDX_W-1:0] lut_idx;
  logic [W-1:0]     lut_data, crc_cur;
  logic [CNT_W-1:0] cnt_cur;
  logic             dp_busy, dp_done;
  logic [1:0]       stat_v;

  assign run     = ctrl_q[0];
  assign locked  = run || dp_busy;
  assign poly_we = reg_we && (reg_addr == ADDR_W'(RA_POLY)) && !locked;
  assign seed_we = reg_we && (reg_addr == ADDR_W'(RA_CUR))  && !locked;
  assign cnt_we  = reg_we && (reg_addr == ADDR_W'(RA_CNT))  && !locked;
  assign go      = run && (ctrl_q[2:1] == MODE_CALC) && lut_done;

  crc_lut #(.W(W), .IDX_W(IDX_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .start(poly_we), .poly(reg_wdata),
    .rd_idx(lut_idx), .rd_data(lut_data), .done(lut_done)
  );

  crc_word_dp #(.W(W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .go(go),
    .seed_we(seed_we), .seed(reg_wdata),
    .cnt_we(cnt_we), .cnt_in(reg_wdata[CNT_W-1:0]), .reload(reload_q),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .lut_idx(lut_idx), .lut_data(lut_data),
    .crc_cur(crc_cur), .cnt_cur(cnt_cur), .busy(dp_busy), .done(dp_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stat_exp <= 1'b0;
      ien_q    <= '0;
      result_q <= '0;
      reload_q <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(RA_CTRL)) ctrl_q <= reg_wdata[2:0];
      if (reg_we && reg_addr == ADDR_W'(RA_IEN))  ien_q  <= ien_q | reg_wdata[1:0];
      if (reg_we && reg_addr == ADDR_W'(RA_RLD))  reload_q <= reg_wdata[CNT_W-1:0];
      if (dp_done) begin
        stat_exp <= 1'b1;
        result_q <= crc_cur;
      end else if (reg_we && reg_addr == ADDR_W'(RA_STAT) && reg_wdata[ST_EXP]) begin
        stat_exp <= 1'b0;
      end
    end
  end

  assign stat_v = {stat_exp, lut_done};
  assign irq    = |(stat_v & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(RA_CTRL): reg_rdata = W'(ctrl_q);
      ADDR_W'(RA_STAT): reg_rdata = W'(stat_v);
      ADDR_W'(RA_IEN):  reg_rdata = W'(ien_q);
      ADDR_W'(RA_CUR):  reg_rdata = crc_cur;
      ADDR_W'(RA_RES):  reg_rdata = result_q;
      ADDR_W'(RA_CNT):  reg_rdata = W'(cnt_cur);
      ADDR_W'(RA_RLD):  reg_rdata = W'(reload_q);
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_word_engine_chk.sv
module crc_word_engine_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              s_valid,
  input logic              s_ready,
  input logic              irq,
  input logic              run,
  input logic              lut_done,
  input logic              stat_exp,
  input logic [CNT_W-1:0]  cnt_cur,
  input logic              dp_done
);
  p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lut_done |-> !s_ready);

  p_run_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !s_ready);

  p_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_cur == '0) |-> !s_ready);

  p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_done |=> stat_exp);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_exp || lut_done));

  p_poly_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(3) && run && lut_done) |=> lut_done);
endmodule

bind crc_word_engine crc_word_engine_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .s_valid(s_valid), .s_ready(s_ready), .irq(irq), .run(run),
  .lut_done(lut_done), .stat_exp(stat_exp), .cnt_cur(cnt_cur), .dp_done(dp_done)
);

// File: tb/crc_word_engine_tb.sv
module crc_word_engine_tb;
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [2:0]  RUN_CALC = 3'b011;

  typedef struct packed {
    logic [31:0] seed;
    logic [3:0]  n;
    logic [31:0] w0;
    logic [31:0] step;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'hFFFFFFFF, 4'd1, 32'h00000000, 32'h0},
    '{32'h00000000, 4'd1, 32'h12345678, 32'h0},
    '{32'hFFFFFFFF, 4'd3, 32'h31323334, 32'h01010101},
    '{32'hA5A5A5A5, 4'd5, 32'hDEADBEEF, 32'h11111111},
    '{32'h00000000, 4'd2, 32'hFFFFFFFF, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc_word_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .irq(irq)
  );

  function automatic logic [31:0] model(input logic [31:0] crc, input logic [31:0] w);
    logic [31:0] c;
    c = crc;
    for (int b = 0; b < 4; b++) begin
      c = c ^ {24'h0, w[b*8 +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    for (int t = 0; t < 400; t++) begin
      #1;
      if (s_ready) break;
      @(negedge clk);
    end
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic wait_exp(input string req);
    logic [31:0] st;
    st = '0;
    for (int t = 0; t < 200; t++) begin
      rd(3'd1, st);
      if (st[1]) break;
    end
    check(req, {31'h0, st[1]}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, crc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    rd(3'd1, v); check("R1 status", v, 32'h0);
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd6, v); check("R1 count", v, 32'h0);
    check("R1 s_ready", {31'h0, s_ready}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2: table build timing and hold-off
    wr(3'd6, 32'd1);
    wr(3'd4, 32'hFFFFFFFF);
    wr(3'd3, POLY);
    wr(3'd0, {29'h0, RUN_CALC});
    #1;
    check("R2 not ready early", {31'h0, s_ready}, 32'h0);
    repeat (254) @(posedge clk);
    #1;
    check("R2 s_ready held off", {31'h0, s_ready}, 32'h0);
    reg_addr = 3'd1; #1;
    check("R2 table bit still clear", reg_rdata & 32'h1, 32'h0);
    @(posedge clk); #1;
    check("R2 table bit set at 256", reg_rdata & 32'h1, 32'h1);
    check("R2 s_ready after table", {31'h0, s_ready}, 32'h1);

    // R3/R4: first word, busy window
    push(32'hCAFEF00D);
    check("R4 ready low after accept", {31'h0, s_ready}, 32'h0);
    wait_exp("R5 expire flag");
    rd(3'd5, v); check("R3 first word crc", v, model(32'hFFFFFFFF, 32'hCAFEF00D));
    rd(3'd6, v); check("R5 count zero", v, 32'h0);
    check("R5 stopped", {31'h0, s_ready}, 32'h0);
    check("R8 irq masked", {31'h0, irq}, 32'h0);

    // R7: write-one-to-clear
    wr(3'd1, 32'h1);
    rd(3'd1, v); check("R7 zero write no clear", v, 32'h3);
    wr(3'd1, 32'h2);
    rd(3'd1, v); check("R7 clear exp keeps table", v, 32'h1);

    // R3/R5: vector table
    foreach (VECS[i]) begin
      wr(3'd0, 32'h0);
      wr(3'd4, VECS[i].seed);
      rd(3'd4, v); check("R11 seed readback", v, VECS[i].seed);
      wr(3'd6, {28'h0, VECS[i].n});
      wr(3'd0, {29'h0, RUN_CALC});
      crc = VECS[i].seed;
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        push(VECS[i].w0 + VECS[i].step * k);
        crc = model(crc, VECS[i].w0 + VECS[i].step * k);
      end
      wait_exp("R5 vector expire");
      rd(3'd5, v); check("R3 vector result", v, crc);
      rd(3'd4, v); check("R11 running crc", v, crc);
      rd(3'd6, v); check("R5 vector count zero", v, 32'h0);
      wr(3'd1, 32'h2);
    end

    // R9: locked writes while running
    rd(3'd4, crc);
    wr(3'd4, 32'h13572468);
    wr(3'd6, 32'd9);
    wr(3'd3, 32'h04C11DB7);
    rd(3'd4, v); check("R9 seed ignored", v, crc);
    rd(3'd6, v); check("R9 count ignored", v, 32'h0);
    rd(3'd1, v); check("R9 poly ignored", v, 32'h1);

    // R8: write-one-to-set enable and irq
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h2);
    wr(3'd2, 32'h0);
    rd(3'd2, v); check("R8 enable kept", v, 32'h2);
    wr(3'd4, 32'h0);
    wr(3'd6, 32'd1);
    wr(3'd7, 32'd2);
    wr(3'd0, {29'h0, RUN_CALC});
    push(32'h00000001);
    wait_exp("R5 reload run expire");
    check("R8 irq asserted", {31'h0, irq}, 32'h1);
    crc = model(32'h0, 32'h00000001);
    rd(3'd5, v); check("R6 first segment", v, crc);
    wr(3'd1, 32'h2);
    #1 check("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R6: reload continues from running crc
    rd(3'd6, v); check("R6 count reloaded", v, 32'd2);
    push(32'h89ABCDEF); crc = model(crc, 32'h89ABCDEF);
    push(32'h76543210); crc = model(crc, 32'h76543210);
    wait_exp("R6 second expire");
    rd(3'd5, v); check("R6 continued crc", v, crc);
    wr(3'd0, 32'h0);
    wr(3'd7, 32'h0);
    wr(3'd1, 32'h2);

    // R10: non-calc mode stalls
    wr(3'd6, 32'd1);
    wr(3'd0, 32'h5);
    #1 check("R10 other mode stalls", {31'h0, s_ready}, 32'h0);
    wr(3'd0, {29'h0, RUN_CALC});
    #1 check("R4 calc mode ready", {31'h0, s_ready}, 32'h1);
    wr(3'd0, 32'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule